// File: doc/BRIEF.md
# Compare and Gated Mode Timer

A 16-bit up-counting timer with two modes. In compare mode it advances on every prescaled timer tick. When the count equals a programmed 16-bit compare value, it raises an interrupt pulse and toggles its output pin. The count is not cleared at a match; it keeps counting and wraps from FFFFh to 0000h. In gated mode it advances only while a synchronised external input is at its active level, which a polarity bit selects. When the count reaches the reload value, the count returns to 0001h and the block interrupts. It also interrupts when the gate input goes inactive.

Software programs the timer through a byte-wide write port, with the timer disabled. The port carries the start count, the compare/reload value, the prescaler, the output's initial level, the input polarity and the mode. A separate write then sets the enable bit. Register map: address 0 is control, 1/2 are count high/low, 3/4 are reload high/low. Control bits: [0] enable, [1] mode (0 compare, 1 gated), [2] polarity (1 active high, 0 active low), [3] initial output level, [6:4] prescale exponent p.

Top module: `cmp_gate_timer`

## Requirements
- R1: In compare mode, with the enable bit written at clock edge E and start count S, irq_o is first high after edge E + (C - S + 1) * 2^p, where C is the compare value. (C - S) is taken modulo 2^16.
- R2: A compare match does not clear the count. The count wraps from FFFFh to 0000h, so with divide 1 the next match follows 65536 cycles after the previous one.
- R3: Ticks occur once every 2^p clocks, where p is control bits [6:4]. The divider restarts from zero whenever the timer is disabled.
- R4: While disabled, tmr_out_o equals control bit 3. While enabled, it toggles on the same edge that raises irq_o for a compare match or a gated reload.
- R5: In gated mode the count advances only while the two-flop synchronised input is at the active level set by control bit 2. In compare mode tmr_in_i has no effect.
- R6: In gated mode, a tick with the count equal to the reload value sets the count to 0001h and raises irq_o on that same edge. Further reloads then follow every R active ticks, where R is the reload value.
- R7: In gated mode, when tmr_in_i becomes inactive before edge A, irq_o is high after edge A+2 for one cycle.
- R8: A 16-bit value is committed only when its low byte is written (address 2 or 4). A high-byte write alone (address 1 or 3) changes nothing.
- R9: While the enable bit is 0, irq_o stays low and the count holds.
- R10: irq_o is a single-cycle pulse per event; after reset irq_o and tmr_out_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| tmr_in_i | input | 1 | Asynchronous gate input |
| tmr_out_o | output | 1 | Timer output level |
| irq_o | output | 1 | Interrupt pulse |

## Verification
The count is not visible, so a wrong count, divider phase or gate decision shows up only as an interrupt at the wrong cycle. The bench therefore measures the exact number of edges from enable, or from a gate change, to each irq_o pulse. A divider or wrap error moves the first interrupt by a whole tick period. A count wrongly cleared at a match moves the second interrupt from 65536 cycles to a few. A missed output toggle shows as a wrong tmr_out_o level sampled on the interrupt cycle itself.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PS_W   = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CNT_HI = 3'd1,
    A_CNT_LO = 3'd2,
    A_RLD_HI = 3'd3,
    A_RLD_LO = 3'd4
  } reg_addr_e;

  // packed MSB first: ps[6:4], init_lvl[3], pol[2], gated[1], en[0]
  typedef struct packed {
    logic [PS_W-1:0] ps;
    logic            init_lvl;
    logic            pol;
    logic            gated;
    logic            en;
  } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output ctrl_t             ctrl_o,
  output logic              cnt_ld_o,
  output logic [CNT_W-1:0]  cnt_val_o,
  output logic [CNT_W-1:0]  rld_o
);
  localparam int unsigned HI_W = CNT_W - BYTE_W;

  logic [HI_W-1:0] cnt_stage_q, rld_stage_q;
  reg_addr_e       addr;

  assign addr      = reg_addr_e'(wr_addr_i);
  assign cnt_ld_o  = wr_en_i && (addr == A_CNT_LO);
  assign cnt_val_o = {cnt_stage_q, wr_data_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o      <= '0;
      cnt_stage_q <= '0;
      rld_stage_q <= '0;
      rld_o       <= '1;
    end else if (wr_en_i) begin
      unique case (addr)
        A_CTRL:   ctrl_o      <= ctrl_t'(wr_data_i[$bits(ctrl_t)-1:0]);
        A_CNT_HI: cnt_stage_q <= wr_data_i[HI_W-1:0];
        A_RLD_HI: rld_stage_q <= wr_data_i[HI_W-1:0];
        A_RLD_LO: rld_o       <= {rld_stage_q, wr_data_i};
        default: ;
      endcase
    end
  end

  // R8: staging a high byte never disturbs the committed reload value
  a_r8_atomic_rld: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr == A_RLD_HI) |=> $stable(rld_o));
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
  parameter int unsigned PS_W = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic [PS_W-1:0] sel_i,
  output logic            tick_o
);
  localparam int unsigned DIV_W = (1 << PS_W) - 1;

  logic [DIV_W-1:0] cnt_q, mask;

  assign mask   = (DIV_W'(1) << sel_i) - DIV_W'(1);
  assign tick_o = en_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (!en_i) cnt_q <= '0;
    else            cnt_q <= cnt_q + DIV_W'(1);
  end

  // R3: divide ratios above one never give back-to-back ticks
  a_r3_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && sel_i != '0) |=> (!tick_o || sel_i != $past(sel_i)));
endmodule

// File: rtl/tmr_in_sync.sv
module tmr_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic in_i,
  input  logic pol_i,
  output logic act_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q;
  logic              act_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      act_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], in_i};
      act_q  <= act_o;
    end
  end

  assign act_o  = pol_i ? sync_q[STAGES-1] : ~sync_q[STAGES-1];
  assign fall_o = act_q & ~act_o;

  // R7: a deassertion event lasts one cycle
  a_r7_fall_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fall_o |=> !fall_o);
endmodule

// File: rtl/cmp_gate_timer.sv
module cmp_gate_timer
  import tmr_pkg::*;
#(
  parameter int unsigned CNT_W       = 2 * BYTE_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              tmr_in_i,
  output logic              tmr_out_o,
  output logic              irq_o
);
  ctrl_t            ctrl;
  logic             cnt_ld, pre_tick, gate_act, gate_fall, tick, hit;
  logic [CNT_W-1:0] cnt_val, rld, count_q;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .ctrl_o(ctrl), .cnt_ld_o(cnt_ld), .cnt_val_o(cnt_val), .rld_o(rld)
  );

  tmr_prescale #(.PS_W(PS_W)) u_pre (
    .clk_i, .rst_ni, .en_i(ctrl.en), .sel_i(ctrl.ps), .tick_o(pre_tick)
  );

  tmr_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .in_i(tmr_in_i), .pol_i(ctrl.pol),
    .act_o(gate_act), .fall_o(gate_fall)
  );

  // compare mode ignores the input pin entirely
  assign tick = pre_tick && (!ctrl.gated || gate_act);
  assign hit  = tick && (count_q == rld);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q   <= '0;
      tmr_out_o <= 1'b0;
      irq_o     <= 1'b0;
    end else begin
      if (cnt_ld)                 count_q <= cnt_val;
      else if (hit && ctrl.gated) count_q <= CNT_W'(1);
      else if (tick)              count_q <= count_q + CNT_W'(1);

      if (!ctrl.en) tmr_out_o <= ctrl.init_lvl;
      else if (hit) tmr_out_o <= ~tmr_out_o;

      irq_o <= ctrl.en && (hit || (ctrl.gated && gate_fall));
    end
  end

  a_r2_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.gated && tick && !cnt_ld && count_q == '1) |=> count_q == '0);

  a_r2_no_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.gated && hit && !cnt_ld) |=> count_q == CNT_W'($past(count_q) + CNT_W'(1)));

  a_r6_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.gated && hit && !cnt_ld) |=> (count_q == CNT_W'(1) && irq_o));

  a_r4_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.en && hit) |=> tmr_out_o != $past(tmr_out_o));

  a_r5_gate_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl.gated && !gate_act && !cnt_ld) |=> $stable(count_q));

  a_r9_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ctrl.en && !cnt_ld) |=> ($stable(count_q) && !irq_o));
endmodule

// File: tb/cmp_gate_timer_bench.sv
`timescale 1ns/1ps
module cmp_gate_timer_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       wr_en = 1'b0, tmr_in = 1'b0, noise = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic       tmr_out, irq;
  int         total = 0, bad = 0;

  cmp_gate_timer u_cmp_gate_timer (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .tmr_in_i(tmr_in), .tmr_out_o(tmr_out), .irq_o(irq)
  );

  always #10 clk = ~clk;

  always @(negedge clk) if (noise) tmr_in <= 1'($urandom);

  function automatic int exp_first(int start, int cmp, int ps);
    return ((((cmp - start) & 32'hFFFF) + 1) << ps);
  endfunction

  function automatic logic [7:0] ctl(bit en, bit gated, bit pol, bit init, int ps);
    return {1'b0, 3'(ps), init, pol, gated, en};
  endfunction

  task automatic check(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = 8'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // k = number of edges passed since the last edge already reflected
  task automatic wait_irq(int max, output int k);
    k = 0;
    while (!irq && k < max) begin
      @(negedge clk); k++;
    end
  endtask

  task automatic setup(int start, int cmp, bit gated, bit pol, bit init, int ps);
    wr(0, ctl(0, gated, pol, init, ps));
    wr(1, start >> 8); wr(2, start & 255);
    wr(3, cmp >> 8);   wr(4, cmp & 255);
  endtask

  task automatic set_in(bit v);
    @(negedge clk); tmr_in = v;
  endtask

  task automatic quiet(string req, int n);
    int seen = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (irq) seen++;
    end
    check(req, seen, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int k;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset irq", irq, 0);
    check("R10 reset out", tmr_out, 0);

    // R4 initial level while disabled
    setup(16'h0010, 16'h0014, 0, 1, 1, 0);
    @(negedge clk);
    check("R4 init level", tmr_out, 1);
    wr(0, ctl(1, 0, 1, 1, 0));
    wait_irq(1000, k);
    check("R1 first match", k, 5);
    check("R4 toggle on match", tmr_out, 0);
    @(negedge clk);
    check("R10 pulse width", irq, 0);

    // R1 R2 wrap through FFFF with divide 2
    setup(16'hFFFE, 16'h0001, 0, 1, 0, 1);
    wr(0, ctl(1, 0, 1, 0, 1));
    wait_irq(1000, k);
    check("R2 wrap match", k, 8);

    // R2 no clear on match: next match a full period later
    setup(5, 5, 0, 1, 0, 0);
    wr(0, ctl(1, 0, 1, 0, 0));
    wait_irq(100, k);
    check("R1 immediate match", k, 1);
    @(negedge clk);
    wait_irq(70000, k);
    check("R2 full period", k + 1, 65536);

    // R3 R5 random compare runs, noisy input must not matter
    noise = 1'b1;
    for (int i = 0; i < 8; i++) begin
      int s = int'($urandom_range(0, 65535));
      int d = int'($urandom_range(0, 63));
      int p = int'($urandom_range(0, 4));
      setup(s, (s + d) & 16'hFFFF, 0, 0, 0, p);
      wr(0, ctl(1, 0, 0, 0, p));
      wait_irq(5000, k);
      check("R3 R5 random compare", k, exp_first(s, (s + d) & 16'hFFFF, p));
    end
    noise = 1'b0;
    tmr_in = 1'b0;

    // R8 high-byte writes without low byte are ignored
    setup(16'h0100, 16'h0103, 0, 1, 0, 0);
    wr(1, 8'hAA); wr(3, 8'h77);
    wr(0, ctl(1, 0, 1, 0, 0));
    wait_irq(1000, k);
    check("R8 atomic commit", k, 4);

    // R9 disable: no interrupt, output back to init, count frozen
    setup(0, 40, 0, 1, 1, 0);
    wr(0, ctl(1, 0, 1, 1, 0));
    repeat (10) @(negedge clk);
    wr(0, ctl(0, 0, 1, 1, 0));
    quiet("R9 disabled quiet", 60);
    check("R9 disabled out", tmr_out, 1);
    wr(0, ctl(1, 0, 1, 1, 0));
    wait_irq(1000, k);
    check("R9 count held", k, 29);

    // gated, active high
    tmr_in = 1'b0;
    setup(0, 10, 1, 1, 0, 0);
    wr(0, ctl(1, 1, 1, 0, 0));
    quiet("R5 gate closed", 30);
    set_in(1);
    wait_irq(1000, k);
    check("R6 first reload", k, 13);
    @(negedge clk);
    wait_irq(1000, k);
    check("R6 reload period", k + 1, 10);
    check("R4 two toggles", tmr_out, 0);
    set_in(0);
    wait_irq(100, k);
    check("R7 deassert irq", k, 3);
    quiet("R5 gate closed hold", 40);
    set_in(1);
    wait_irq(1000, k);
    check("R5 resume count", k, 9);

    // gated, active low
    tmr_in = 1'b1;
    setup(0, 3, 1, 0, 0, 0);
    wr(0, ctl(1, 1, 0, 0, 0));
    quiet("R5 low pol idle", 20);
    set_in(0);
    wait_irq(1000, k);
    check("R5 low polarity", k, 6);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule